// File: doc/BRIEF.md
# Quadrature Encoder Counter

This block is the quadrature front end of a general-purpose timer. It takes the two phase signals of an incremental encoder, plus one auxiliary channel, and turns them into a position count with a direction flag that the hardware maintains itself. Each phase is brought into the core clock domain. It then passes through an optional sampled glitch filter and a polarity inverter before edge detection. The first phase can instead be formed as the XOR of all three channels.

A two-bit mode input picks which transitions are counted: those of phase 0 only, those of phase 1 only, or both, which gives four counts per encoder cycle. The relative level of the other phase decides whether a counted transition steps the count up or down. The count lives in the range from zero to a programmable reload value. It wraps in both directions and gives a one-cycle pulse on every wrap. The reload value is meant to be set before counting is enabled.

Top module: `qdec_counter`

## Requirements
- R1: While reset is asserted and on the first cycles after it, `count` is 0, `dir_down` is 0 and `wrap_pulse` is 0.
- R2: `mode` = 1 counts transitions of phase 0 only, `mode` = 2 counts transitions of phase 1 only, `mode` = 3 counts both, and `mode` = 0 counts nothing. A transition of a phase that is not selected leaves count and direction unchanged.
- R3: On a counted transition of phase 0, the count goes up when phase 1 differs from the new phase 0 level and goes down otherwise. On a counted transition of phase 1, the count goes up when the new phase 1 level equals phase 0 and goes down otherwise. Every counted step is exactly ±1 unless it wraps. `dir_down` is set to 1 for a down step and 0 for an up step.
- R4: An up step from a count equal to (or above) `reload` gives 0, and `wrap_pulse` is high for one cycle.
- R5: A down step from 0 gives `reload`, and `wrap_pulse` is high for one cycle.
- R6: When both conditioned phases change in the same clock, the transition is invalid and count and direction stay unchanged.
- R7: While `enable` is low, count and direction hold and no wrap pulse is made. Transitions seen during that time are discarded, not replayed when `enable` returns high.
- R8: `pol_inv[0]` inverts phase 0 and `pol_inv[1]` inverts phase 1 after the filter and before edge detection, so inverting phase 0 reverses the direction of its steps.
- R9: With `xor_sel` = 1, phase 0 is `enc_a ^ enc_b ^ enc_x`. With `xor_sel` = 0 it is `enc_a`. Phase 1 is always `enc_b`.
- R10: With `filt_len` = N > 0, a phase takes a new level only after N consecutive sample ticks see that level. A tick occurs every `samp_div`+1 core clocks. With N = 0 the filter is bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Counting enable |
| mode | input | 2 | Edge source: 0 none, 1 phase 0, 2 phase 1, 3 both |
| xor_sel | input | 1 | Phase 0 taken from XOR of the three channels |
| pol_inv | input | 2 | Per-phase inversion, bit 0 for phase 0 |
| filt_len | input | FILT_W | Consecutive samples required by the filter, 0 = bypass |
| samp_div | input | DIV_W | Sample tick period minus one, in core clocks |
| reload | input | CNT_W | Upper bound of the count |
| enc_a | input | 1 | Encoder channel 0 |
| enc_b | input | 1 | Encoder channel 1 |
| enc_x | input | 1 | Auxiliary channel for the XOR combiner |
| count | output | CNT_W | Position count |
| dir_down | output | 1 | Direction of the last counted step, 1 = down |
| wrap_pulse | output | 1 | One-cycle pulse on a wrap in either direction |

## Verification
The hardest cases to reach are a transition that would look plausible but must not count: both phases changing in one clock, an edge made by flipping polarity or the XOR source, and pulses slightly shorter than the filter window. The bench reaches the first by changing both channels on the same negative edge, so that the synchronizers deliver the two changes in the same cycle. It reaches the second by changing configuration only while `enable` is low, and then checks that the next real edge steps in the expected direction. For the filter it uses glitches of two clocks with ticks every clock, and of six clocks with ticks every fourth clock, each one sample short of acceptance. Each glitch is followed by a long pulse that must be counted.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
    typedef enum logic [1:0] {
        QM_NONE = 2'd0,
        QM_PH0  = 2'd1,
        QM_PH1  = 2'd2,
        QM_BOTH = 2'd3
    } qmode_e;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stab;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = din;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.stab;
endmodule

// File: rtl/qdec_tick.sv
module qdec_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] samp_div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             tick;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.div >= samp_div) begin
            st_d.div  = '0;
            st_d.tick = 1'b1;
        end else begin
            st_d.div  = st_q.div + 1'b1;
            st_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;
endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
    parameter int FILT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [FILT_W-1:0] len,
    input  logic              din,
    output logic              dout
);
    localparam logic [FILT_W-1:0] ONE = FILT_W'(1);

    typedef struct packed {
        logic [FILT_W-1:0] run;
        logic              lvl;
    } filt_st_t;

    filt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (len == '0) begin
            st_d.lvl = din;
            st_d.run = '0;
        end else if (tick) begin
            if (din == st_q.lvl) begin
                st_d.run = '0;
            end else if (st_q.run >= len - ONE) begin
                st_d.lvl = din;
                st_d.run = '0;
            end else begin
                st_d.run = st_q.run + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.lvl;
endmodule

// File: rtl/qdec_core.sv
module qdec_core
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       mode,
    input  logic             ph0,
    input  logic             ph1,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             wrap_pulse
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic             wrap;
        logic             prev0;
        logic             prev1;
    } core_st_t;

    core_st_t st_d, st_q;
    qmode_e   mode_e;
    logic     edge0, edge1, take0, take1, step, go_up;

    assign mode_e = qmode_e'(mode);

    always_comb begin
        st_d       = st_q;
        st_d.wrap  = 1'b0;
        st_d.prev0 = ph0;
        st_d.prev1 = ph1;

        edge0 = ph0 ^ st_q.prev0;
        edge1 = ph1 ^ st_q.prev1;
        take0 = edge0 && (mode_e == QM_PH0 || mode_e == QM_BOTH);
        take1 = edge1 && (mode_e == QM_PH1 || mode_e == QM_BOTH);
        step  = enable && (take0 || take1) && !(edge0 && edge1);
        go_up = take0 ? (ph0 != ph1) : (ph1 == ph0);

        if (step) begin
            st_d.down = !go_up;
            if (go_up) begin
                if (st_q.cnt >= reload) begin
                    st_d.cnt  = '0;
                    st_d.wrap = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.cnt  = reload;
                    st_d.wrap = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count      = st_q.cnt;
    assign dir_down   = st_q.down;
    assign wrap_pulse = st_q.wrap;
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter #(
    parameter int CNT_W  = 16,
    parameter int FILT_W = 4,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        mode,
    input  logic              xor_sel,
    input  logic [1:0]        pol_inv,
    input  logic [FILT_W-1:0] filt_len,
    input  logic [DIV_W-1:0]  samp_div,
    input  logic [CNT_W-1:0]  reload,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              enc_x,
    output logic [CNT_W-1:0]  count,
    output logic              dir_down,
    output logic              wrap_pulse
);
    localparam int NCH  = 3;
    localparam int NPH  = 2;

    logic [NCH-1:0] ch_sync;
    logic [NPH-1:0] ph_raw;
    logic [NPH-1:0] ph_filt;
    logic [NPH-1:0] ph_cond;
    logic           samp_tick;

    qdec_sync #(.W(NCH)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({enc_x, enc_b, enc_a}),
        .dout (ch_sync)
    );

    qdec_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .samp_div(samp_div),
        .tick    (samp_tick)
    );

    always_comb begin
        ph_raw[0] = xor_sel ? ^ch_sync : ch_sync[0];
        ph_raw[1] = ch_sync[1];
    end

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        qdec_filter #(.FILT_W(FILT_W)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (samp_tick),
            .len  (filt_len),
            .din  (ph_raw[g]),
            .dout (ph_filt[g])
        );
        assign ph_cond[g] = ph_filt[g] ^ pol_inv[g];
    end

    qdec_core #(.CNT_W(CNT_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .mode      (mode),
        .ph0       (ph_cond[0]),
        .ph1       (ph_cond[1]),
        .reload    (reload),
        .count     (count),
        .dir_down  (dir_down),
        .wrap_pulse(wrap_pulse)
    );
endmodule

// File: rtl/qdec_counter_chk.sv
module qdec_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] count,
    input logic             dir_down,
    input logic             wrap_pulse
);
    AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_pulse && !dir_down) |-> (count == '0)); // R4

    AST_DOWN_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_pulse && dir_down) |-> (count == reload)); // R5

    AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> ($stable(count) && $stable(dir_down) && !wrap_pulse)); // R7

    AST_MODE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |=> ($stable(count) && !wrap_pulse)); // R2

    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) |-> (wrap_pulse
                             || count == CNT_W'($past(count) + 1'b1)
                             || count == CNT_W'($past(count) - 1'b1))); // R3
endmodule

bind qdec_counter qdec_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .mode      (mode),
    .reload    (reload),
    .count     (count),
    .dir_down  (dir_down),
    .wrap_pulse(wrap_pulse)
);

// File: tb/test_qdec_counter.sv
module test_qdec_counter;
    localparam int CNT_W  = 16;
    localparam int FILT_W = 4;
    localparam int DIV_W  = 8;
    localparam int NVEC   = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enable = 1'b1;
    logic [1:0]        mode = 2'd3;
    logic              xor_sel = 1'b0;
    logic [1:0]        pol_inv = 2'b00;
    logic [FILT_W-1:0] filt_len = '0;
    logic [DIV_W-1:0]  samp_div = '0;
    logic [CNT_W-1:0]  reload = 16'd5;
    logic              enc_a = 1'b0;
    logic              enc_b = 1'b0;
    logic              enc_x = 1'b0;
    logic [CNT_W-1:0]  count;
    logic              dir_down;
    logic              wrap_pulse;

    int total = 0;
    int bad = 0;
    int wraps = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    qdec_counter #(.CNT_W(CNT_W), .FILT_W(FILT_W), .DIV_W(DIV_W)) i_qdec_counter (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .xor_sel(xor_sel),
        .pol_inv(pol_inv), .filt_len(filt_len), .samp_div(samp_div), .reload(reload),
        .enc_a(enc_a), .enc_b(enc_b), .enc_x(enc_x),
        .count(count), .dir_down(dir_down), .wrap_pulse(wrap_pulse)
    );

    always @(posedge clk) if (rst_n && wrap_pulse) wraps++;

    // {a, b, expected count[7:0], expected dir_down, cumulative wraps[3:0]}
    // reload = 5, mode = 3, filter bypassed
    localparam logic [14:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'd1, 1'b0, 4'd0},
        {1'b1, 1'b1, 8'd2, 1'b0, 4'd0},
        {1'b0, 1'b1, 8'd3, 1'b0, 4'd0},
        {1'b0, 1'b0, 8'd4, 1'b0, 4'd0},
        {1'b1, 1'b0, 8'd5, 1'b0, 4'd0},
        {1'b1, 1'b1, 8'd0, 1'b0, 4'd1},
        {1'b1, 1'b0, 8'd5, 1'b1, 4'd2},
        {1'b0, 1'b0, 8'd4, 1'b1, 4'd2},
        {1'b0, 1'b1, 8'd3, 1'b1, 4'd2},
        {1'b1, 1'b1, 8'd2, 1'b1, 4'd2}
    };

    task automatic check_val(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_state(input string req, input int exp_cnt, input int exp_dir);
        check_val({req, " count"}, int'(count), exp_cnt);
        check_val({req, " dir_down"}, int'(dir_down), exp_dir);
    endtask

    task automatic drive(input logic a, input logic b, input logic x);
        @(negedge clk);
        enc_a = a; enc_b = b; enc_x = x;
        repeat (8) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        check_state("R1 in reset", 0, 0);
        check_val("R1 wrap in reset", int'(wrap_pulse), 0);
        rst_n = 1'b1;
        idle(4);
        check_state("R1 after reset", 0, 0);
        check_val("R1 wrap after reset", int'(wrap_pulse), 0);

        // R3 R4 R5: forward run with up-wrap, then reverse with down-wrap
        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][14], VEC[i][13], 1'b0);
            check_state("R3 table", int'(VEC[i][12:5]), int'(VEC[i][4]));
            check_val("R4 R5 table wraps", wraps, int'(VEC[i][3:0]));
        end

        // R6: both phases change together (11 -> 00)
        drive(1'b0, 1'b0, 1'b0);
        check_state("R6 simultaneous", 2, 1);

        // R2: mode 1, phase 1 ignored
        mode = 2'd1;
        drive(1'b0, 1'b1, 1'b0);
        check_state("R2 mode1 ignores ph1", 2, 1);
        drive(1'b1, 1'b1, 1'b0);
        check_state("R2 mode1 ph0 down", 1, 1);
        drive(1'b0, 1'b1, 1'b0);
        check_state("R2 mode1 ph0 up", 2, 0);

        // R2: mode 2, phase 0 ignored
        mode = 2'd2;
        drive(1'b1, 1'b1, 1'b0);
        check_state("R2 mode2 ignores ph0", 2, 0);
        drive(1'b1, 1'b0, 1'b0);
        check_state("R2 mode2 ph1 down", 1, 1);

        // R2: mode 0 counts nothing
        mode = 2'd0;
        drive(1'b0, 1'b0, 1'b0);
        check_state("R2 mode0", 1, 1);
        mode = 2'd3;
        idle(2);

        // R7: disabled edges are dropped, not replayed
        enable = 1'b0;
        drive(1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0);
        check_state("R7 hold while disabled", 1, 1);
        enable = 1'b1;
        idle(4);
        check_state("R7 no replay", 1, 1);
        drive(1'b0, 1'b1, 1'b0);
        check_state("R7 resume", 2, 0);

        // R8: phase 0 inverted; raw a rise with b=1 now counts up
        enable = 1'b0;
        pol_inv = 2'b01;
        idle(3);
        enable = 1'b1;
        drive(1'b1, 1'b1, 1'b0);
        check_state("R8 inverted ph0", 3, 0);
        enable = 1'b0;
        pol_inv = 2'b00;
        idle(3);
        enable = 1'b1;

        // R9: phase 0 from XOR, toggled through enc_x in mode 1
        enable = 1'b0;
        xor_sel = 1'b1;
        mode = 2'd1;
        idle(3);
        enable = 1'b1;
        drive(1'b1, 1'b1, 1'b1);
        check_state("R9 xor ph0 rise", 2, 1);
        drive(1'b1, 1'b1, 1'b0);
        check_state("R9 xor ph0 fall", 3, 0);
        enable = 1'b0;
        xor_sel = 1'b0;
        mode = 2'd3;
        idle(3);
        enable = 1'b1;

        // R10: filter of 3 samples, tick every clock
        filt_len = 4'd3;
        samp_div = 8'd0;
        @(negedge clk); enc_a = 1'b0;
        idle(2);
        enc_a = 1'b1;
        idle(10);
        check_state("R10 short glitch rejected", 3, 0);
        @(negedge clk); enc_a = 1'b0;
        idle(12);
        check_state("R10 long level accepted", 4, 0);

        // R10: tick every 4 clocks, 6-clock glitch too short
        samp_div = 8'd3;
        @(negedge clk); enc_a = 1'b1;
        idle(6);
        enc_a = 1'b0;
        idle(30);
        check_state("R10 divided glitch rejected", 4, 0);
        @(negedge clk); enc_a = 1'b1;
        idle(30);
        check_state("R10 divided level accepted", 3, 1);
        check_val("R4 R5 no extra wraps", wraps, 2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule